// File: doc/BRIEF.md
# Three-Bit Quasi-Bidirectional Port with Edge Interrupt

The block is a small general-purpose I/O port on a byte-wide controller bus. Software writes an output latch at one address and reads the pin levels at another. Each pin is modelled as an open-drain output with its own input signal. A latch bit of 1 releases the pin, so the pin can be used as an input or for its alternate function. A latch bit of 0 pulls the pin low.

Pin 0 also acts as an external interrupt source and as a stop-mode wake input. A falling edge on the synchronised pin raises a one-cycle interrupt request. This happens even when the port's own latch pulled the pin low. While the dual-clock mode input is high, pins 1 and 2 belong to a low-frequency crystal oscillator. The port then never pulls them low, and their bits in the pin register read 0.

Top module: `gpio3_port`

## Requirements
- R1: After a synchronous active-high reset, all three latch bits are 1, no pin is pulled low and `irq_pulse` is 0.
- R2: A bus write (`bus_wr`=1) to address 0x02 loads `bus_wdata[2:0]` into the latch on the next clock edge. A read (`bus_rd`=1) of address 0x02 returns the latch in `bus_rdata[2:0]`, not the pin levels.
- R3: A read of address 0x0A returns in `bus_rdata[2:0]` the pin levels after a two-flop synchroniser. A pin change that is set up before edge k is visible after edge k+1.
- R4: In single-clock mode (`dual_clk`=0), `pin_drive_low[i]` is 1 exactly when latch bit i is 0.
- R5: In dual-clock mode (`dual_clk`=1), `osc_enable` is 1, `pin_drive_low[2:1]` stays 0 and pin-register bits 2:1 read 0. Bit 0 keeps its normal behaviour.
- R6: `irq_pulse` is high for exactly one cycle after the synchronised bit 0 goes from 1 to 0, which is the cycle after edge k+1. A rising level never raises it.
- R7: Writing 0 to latch bit 0 while the pin is otherwise high raises `irq_pulse` through the pin's own falling edge.
- R8: `stop_release` equals the inverse of the synchronised bit-0 level.
- R9: Writes to any address other than 0x02 leave the latch unchanged. `bus_rdata` is 0 when `bus_rd` is low or the address is unmapped. Bits 7:3 are undefined and are masked by the checker.
- R10: In dual-clock mode, latch bits 2:1 can still be written and read back at 0x02, while those pins stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (bits 7:3 undefined) |
| dual_clk | input | 1 | 1 hands pins 2:1 to the oscillator |
| pin_in | input | 3 | Sensed pin levels |
| pin_drive_low | output | 3 | 1 pulls the pin low, 0 releases it |
| osc_enable | output | 1 | Oscillator enable for pins 2:1 |
| irq_pulse | output | 1 | One-cycle falling-edge request from pin 0 |
| stop_release | output | 1 | High while synchronised pin 0 is low |

## Verification
Two things can land in the same cycle: a latch write to 0x02 and the interrupt pulse that an earlier write caused. A read of 0x0A can also coincide with the cycle in which `irq_pulse` fires. The bench provokes both by feeding the pulled-low outputs back into `pin_in`. It then issues random bus traffic while bit 0 toggles, from outside and from the latch. Every cycle, the pin-register bit 0, `stop_release` and `irq_pulse` are compared with a bench model. The model keeps its own latch and synchroniser, so a wrong ordering between the read path and the edge path shows up as a mismatch.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;

    localparam int PORT_W = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] DEF_LATCH_ADDR = 8'h02;
    localparam logic [ADDR_W-1:0] DEF_PIN_ADDR   = 8'h0A;

    // pins surrendered to the oscillator in dual-clock mode
    localparam logic [PORT_W-1:0] OSC_PINS = 3'b110;

    typedef enum logic {
        CLK_SINGLE = 1'b0,
        CLK_DUAL   = 1'b1
    } clk_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_PIN   = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] drive_low;
        logic              osc_en;
    } pin_ctrl_t;

    function automatic logic [PORT_W-1:0] usable_mask(input clk_mode_e mode);
        return (mode == CLK_DUAL) ? ~OSC_PINS : {PORT_W{1'b1}};
    endfunction

    function automatic rd_sel_e decode_addr(input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] latch_a,
                                            input logic [ADDR_W-1:0] pin_a);
        if (a == latch_a)    return SEL_LATCH;
        else if (a == pin_a) return SEL_PIN;
        else                 return SEL_NONE;
    endfunction

endpackage

// File: rtl/gpio3_in_sync.sv
module gpio3_in_sync
    import gpio3_pkg::*;
#(
    parameter int          WIDTH   = PORT_W,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R3
            sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (dout == $past(din, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio3_bus_regs.sv
module gpio3_bus_regs
    import gpio3_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LATCH_ADDR = DEF_LATCH_ADDR,
    parameter logic [ADDR_W-1:0] PIN_ADDR   = DEF_PIN_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_sync,
    input  clk_mode_e         mode,
    output logic [PORT_W-1:0] latch,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - PORT_W;

    rd_sel_e sel;
    logic    wr_latch;

    assign sel      = decode_addr(addr, LATCH_ADDR, PIN_ADDR);
    assign wr_latch = wr && (sel == SEL_LATCH);

    always_ff @(posedge clk) begin
        if (rst)           latch <= '1;
        else if (wr_latch) latch <= wdata[PORT_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (sel)
                SEL_LATCH: rdata = {{PAD_W{1'b0}}, latch};
                SEL_PIN:   rdata = {{PAD_W{1'b0}}, pin_sync & usable_mask(mode)};
                default:   rdata = '0;
            endcase
        end
    end

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == LATCH_ADDR) |=> (latch == $past(wdata[PORT_W-1:0])));
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == LATCH_ADDR) |=> $stable(latch));
    // R1
    latch_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (latch == '1));
endmodule

// File: rtl/gpio3_edge_detect.sv
module gpio3_edge_detect
    import gpio3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic irq,
    output logic stop_rel
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= lvl;
    end

    assign irq      = prev & ~lvl;
    assign stop_rel = ~lvl;

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
endmodule

// File: rtl/gpio3_pin_ctrl.sv
module gpio3_pin_ctrl
    import gpio3_pkg::*;
(
    input  logic [PORT_W-1:0] latch,
    input  clk_mode_e         mode,
    output pin_ctrl_t         ctrl
);
    logic [PORT_W-1:0] own_mask;

    assign own_mask       = usable_mask(mode);
    assign ctrl.drive_low = ~latch & own_mask;
    assign ctrl.osc_en    = (mode == CLK_DUAL);

    // R5
    always_comb begin
        osc_pins_free_chk: assert (!ctrl.osc_en || ((ctrl.drive_low & OSC_PINS) == '0));
    end
endmodule

// File: rtl/gpio3_port.sv
module gpio3_port
    import gpio3_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LATCH_ADDR  = DEF_LATCH_ADDR,
    parameter logic [ADDR_W-1:0] PIN_ADDR    = DEF_PIN_ADDR,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dual_clk,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_drive_low,
    output logic              osc_enable,
    output logic              irq_pulse,
    output logic              stop_release
);
    clk_mode_e         mode;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] latch;
    pin_ctrl_t         ctrl;

    assign mode = clk_mode_e'(dual_clk);

    gpio3_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL({PORT_W{1'b1}})) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpio3_bus_regs #(.LATCH_ADDR(LATCH_ADDR), .PIN_ADDR(PIN_ADDR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .mode     (mode),
        .latch    (latch),
        .rdata    (bus_rdata)
    );

    gpio3_pin_ctrl u_pins (
        .latch (latch),
        .mode  (mode),
        .ctrl  (ctrl)
    );

    gpio3_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .lvl      (pin_sync[0]),
        .irq      (irq_pulse),
        .stop_rel (stop_release)
    );

    assign pin_drive_low = ctrl.drive_low;
    assign osc_enable    = ctrl.osc_en;

    // R8
    stop_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> stop_release);
    // R5
    dual_pin_read_chk: assert property (@(posedge clk) disable iff (rst)
        (dual_clk && bus_rd && bus_addr == PIN_ADDR) |-> (bus_rdata[2:1] == 2'b00));
    // R4
    single_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!dual_clk && $past(bus_wr && bus_addr == LATCH_ADDR)) |->
            (pin_drive_low == ~$past(bus_wdata[PORT_W-1:0])));
endmodule

// File: tb/gpio3_port_bench.sv
module gpio3_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       dual = 1'b0;
    logic [2:0] ext = 3'b111;
    logic [2:0] pin_in;
    logic [7:0] rdata;
    logic [2:0] drive_low;
    logic       osc_en, irq, stop_rel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign pin_in = ext & ~drive_low;

    gpio3_port u_gpio3_port (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .dual_clk(dual), .pin_in(pin_in),
        .pin_drive_low(drive_low), .osc_enable(osc_en), .irq_pulse(irq),
        .stop_release(stop_rel)
    );

    // reference model built from the requirements
    logic [2:0] m_latch = 3'b111, m_s1 = 3'b111, m_s2 = 3'b111;
    logic       m_prev = 1'b1;

    function automatic logic [2:0] f_drive(input logic [2:0] l, input logic d);
        return ~l & (d ? 3'b001 : 3'b111);
    endfunction

    function automatic logic [2:0] f_rdata(input logic [7:0] a, input logic r,
                                           input logic [2:0] l, input logic [2:0] s,
                                           input logic d);
        if (!r)         return 3'b000;
        if (a == 8'h02) return l;
        if (a == 8'h0A) return s & (d ? 3'b001 : 3'b111);
        return 3'b000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_latch <= 3'b111; m_s1 <= 3'b111; m_s2 <= 3'b111; m_prev <= 1'b1;
        end else begin
            m_s1   <= ext & ~f_drive(m_latch, dual);
            m_s2   <= m_s1;
            m_prev <= m_s2[0];
            if (wr && addr == 8'h02) m_latch <= wdata[2:0];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [2:0] e_dl, e_rd;
        e_dl = f_drive(m_latch, dual);
        e_rd = f_rdata(addr, rd, m_latch, m_s2, dual);
        chk(drive_low == e_dl, dual ? "R5" : "R4", "drive_low", drive_low, e_dl);
        chk(osc_en == dual, "R5", "osc_enable", osc_en, dual);
        chk(irq == (m_prev & ~m_s2[0]), "R6", "irq_pulse", irq, m_prev & ~m_s2[0]);
        chk(stop_rel == ~m_s2[0], "R8", "stop_release", stop_rel, ~m_s2[0]);
        chk(rdata[2:0] == e_rd, (addr == 8'h0A) ? "R3" : "R2", "rdata", rdata[2:0], e_rd);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic idle();
        wr = 1'b0; rd = 1'b0; addr = 8'h00; wdata = 8'h00;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        int irq_seen;
        seed = 32'd4242;
        void'($urandom(seed));
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1 during reset outputs
        chk(drive_low == 3'b000, "R1", "drive_low in reset", drive_low, 0);
        chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
        rst = 1'b0;
        rd = 1'b1; addr = 8'h02;
        tick();
        chk(rdata[2:0] == 3'b111, "R1", "latch after reset", rdata[2:0], 7);

        // R6 / R3 directed external falling edge on bit 0
        idle(); tick(); tick(); tick();
        rd = 1'b1; addr = 8'h0A; ext = 3'b110;
        tick();
        chk(rdata[0] == 1'b1, "R3", "pin0 after one edge", rdata[0], 1);
        chk(irq == 1'b0, "R6", "irq too early", irq, 0);
        tick();
        chk(rdata[0] == 1'b0, "R3", "pin0 after two edges", rdata[0], 0);
        chk(irq == 1'b1, "R6", "irq on fall", irq, 1);
        tick();
        chk(irq == 1'b0, "R6", "irq one cycle only", irq, 0);
        ext = 3'b111;
        irq_seen = 0;
        for (int i = 0; i < 5; i++) begin tick(); if (irq) irq_seen++; end
        chk(irq_seen == 0, "R6", "no irq on rise", irq_seen, 0);

        // R7 own latch write pulls pin 0 low
        idle(); addr = 8'h02; wr = 1'b1; wdata = 8'hFE;
        tick();
        idle();
        irq_seen = 0;
        for (int i = 0; i < 6; i++) begin tick(); if (irq) irq_seen++; end
        chk(irq_seen == 1, "R7", "irq from own edge", irq_seen, 1);
        chk(drive_low == 3'b001, "R4", "bit0 driven", drive_low, 1);

        // R9 writes to other addresses ignored
        addr = 8'h03; wr = 1'b1; wdata = 8'h00; tick();
        addr = 8'h0A; wr = 1'b1; wdata = 8'h00; tick();
        idle(); rd = 1'b1; addr = 8'h02; tick();
        chk(rdata[2:0] == 3'b110, "R9", "latch kept", rdata[2:0], 6);
        addr = 8'h55; tick();
        chk(rdata[2:0] == 3'b000, "R9", "unmapped read", rdata[2:0], 0);

        // R10 dual mode: latch writable, osc pins released
        dual = 1'b1; idle(); addr = 8'h02; wr = 1'b1; wdata = 8'h00; tick();
        idle(); rd = 1'b1; addr = 8'h02; tick();
        chk(rdata[2:0] == 3'b000, "R10", "dual latch readback", rdata[2:0], 0);
        chk(drive_low == 3'b001, "R10", "dual pins released", drive_low, 1);
        ext = 3'b111; addr = 8'h0A; tick(); tick(); tick();
        chk(rdata[2:1] == 2'b00, "R5", "dual pin read", rdata[2:1], 0);
        dual = 1'b0; idle(); addr = 8'h02; wr = 1'b1; wdata = 8'hFF; tick();
        idle();

        // random traffic checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            case (r[1:0])
                2'd0, 2'd1: addr = 8'h02;
                2'd2:       addr = 8'h0A;
                default:    addr = 8'($urandom);
            endcase
            wr    = (r[4:2] == 3'd0);
            rd    = r[5];
            wdata = 8'($urandom);
            if (r[11:6] == 6'd0) dual = ~dual;
            if (r[13:12] == 2'd0) ext = 3'($urandom);
            tick();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule